// File: doc/BRIEF.md
# Dead-Band Complementary Pair Generator

This block turns a single pulse-width-modulated drive signal into a pair of complementary gate signals with guard time inserted at both transitions. The high-side output follows the drive signal, but each of its rising edges is postponed by a programmable number of clock ticks. The low-side output follows the inverse of the drive signal, and each of its rising edges is postponed by a second, independently programmed number of ticks. Falling edges are never postponed. Because of this, the two outputs can never be high at the same time while the guard function is on.

When the guard function is switched off, the block is transparent. The high-side output copies the drive signal and the low-side output copies a separate raw input, so the two channels are independent. Both delay values are read live on every clock edge. Every output is registered, so an unpostponed transition appears on the clock edge after it is sampled.

A run-length counter measures how many consecutive clock edges the drive signal has held its present level. Each output compares that run length against its own delay. The counter saturates, so a level that is held indefinitely keeps its output asserted.

Top module: `deadband_gen`

## Requirements
- R1: While `rst_n` is low, both outputs are 0. After reset, the block behaves as if `a_in` had just become low.
- R2: With `db_en` = 0, `out_a` equals `a_in` and `out_b` equals `b_in`, each as sampled on the previous clock edge.
- R3: With `db_en` = 1, `out_a` is 1 after an edge at which `a_in` has been sampled 1 on at least `rise_dly`+1 consecutive edges, counting that edge.
- R4: With `db_en` = 1, `out_a` is 0 after any edge at which `a_in` is sampled 0.
- R5: With `db_en` = 1, `out_b` is 1 after an edge at which `a_in` has been sampled 0 on at least `fall_dly`+1 consecutive edges, counting that edge.
- R6: With `db_en` = 1, `out_b` is 0 after any edge at which `a_in` is sampled 1.
- R7: With `db_en` = 1, `b_in` has no effect on either output.
- R8: A high run of `a_in` lasting N edges with N ≤ `rise_dly` leaves `out_a` low for the whole run. A low run lasting N ≤ `fall_dly` leaves `out_b` low for the whole run.
- R9: A delay of 0 adds no postponement, so the affected output follows `a_in` (or its inverse) one edge later.
- R10: After an edge at which `db_en` is 1, `out_a` and `out_b` are never both 1.
- R11: The maximum delay of 4095 ticks is honoured exactly, and a level held longer than 4096 edges keeps its output asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick of delay per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| db_en | input | 1 | 1 = guard mode, 0 = transparent |
| rise_dly | input | 12 | Ticks added to each rising edge of `out_a` |
| fall_dly | input | 12 | Ticks added to each rising edge of `out_b` |
| a_in | input | 1 | Drive signal for the high side |
| b_in | input | 1 | Raw low-side signal, used only when transparent |
| out_a | output | 1 | High-side output |
| out_b | output | 1 | Low-side output |

## Verification
Every output transition is due on the first clock edge after the sample that causes it. In guard mode, a rising edge is due exactly `dly` edges after that point. The bench drives inputs at the falling edge and updates its run-length model on the rising edge. It then compares both outputs at the next falling edge, so each expectation is compared in the cycle where the registered output takes its new value. The sweep covers every combination of small delays and pulse lengths. Pulses both shorter and longer than each delay are therefore checked for their exact rise cycle.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    // Which path feeds the output registers
    typedef enum logic {
        DB_BYPASS = 1'b0,
        DB_GUARD  = 1'b1
    } db_path_e;

    localparam int unsigned DB_CHANNELS = 2;
endpackage

// File: rtl/dbg_run_timer.sv
// Counts how many consecutive earlier edges sampled the same level as a_in now.
module dbg_run_timer #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         a_in,
    output logic [W-1:0] prior
);
    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_ONE = W'(1);

    typedef struct packed {
        logic         lvl;
        logic [W-1:0] cnt;
    } run_t;

    run_t run_d, run_q;

    always_comb begin
        prior     = (a_in == run_q.lvl) ? run_q.cnt : '0;
        run_d.lvl = a_in;
        run_d.cnt = (prior == CNT_MAX) ? CNT_MAX : prior + CNT_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end
endmodule

// File: rtl/dbg_guard.sv
// One output channel: active once its level has been held for more than dly edges.
module dbg_guard #(
    parameter int unsigned W      = 12,
    parameter bit          ACTIVE = 1'b1
) (
    input  logic         a_in,
    input  logic [W-1:0] prior,
    input  logic [W-1:0] dly,
    output logic         on
);
    always_comb begin
        on = (a_in == ACTIVE) && (prior >= dly);
    end
endmodule

// File: rtl/deadband_gen.sv
module deadband_gen #(
    parameter int unsigned DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             db_en,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    input  logic             a_in,
    input  logic             b_in,
    output logic             out_a,
    output logic             out_b
);
    import dbg_pkg::*;

    typedef struct packed {
        logic a;
        logic b;
    } pair_t;

    logic [DLY_W-1:0] prior;
    logic [DLY_W-1:0] dly_arr [DB_CHANNELS];
    logic             guard_on [DB_CHANNELS];
    db_path_e         path;
    pair_t            o_d, o_q;

    dbg_run_timer #(.W(DLY_W)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .a_in  (a_in),
        .prior (prior)
    );

    assign dly_arr[0] = rise_dly;
    assign dly_arr[1] = fall_dly;

    // Channel 0 is active while a_in is high, channel 1 while it is low
    for (genvar g = 0; g < DB_CHANNELS; g++) begin : g_chan
        localparam bit ACT = (g == 0);
        dbg_guard #(.W(DLY_W), .ACTIVE(ACT)) u_guard (
            .a_in  (a_in),
            .prior (prior),
            .dly   (dly_arr[g]),
            .on    (guard_on[g])
        );
    end

    always_comb begin
        path = db_en ? DB_GUARD : DB_BYPASS;
        case (path)
            DB_GUARD: begin
                o_d.a = guard_on[0];
                o_d.b = guard_on[1];
            end
            default: begin
                o_d.a = a_in;
                o_d.b = b_in;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_a = o_q.a;
    assign out_b = o_q.b;
endmodule

// File: rtl/dbg_checker.sv
module dbg_checker #(
    parameter int unsigned W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         db_en,
    input logic [W-1:0] rise_dly,
    input logic         a_in,
    input logic         b_in,
    input logic         out_a,
    input logic         out_b
);
    // Set one edge after reset release so that $past values are valid
    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !$past(db_en) |-> (out_a == $past(a_in)) && (out_b == $past(b_in)));

    assert_a_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(db_en) && !$past(a_in) |-> !out_a);

    assert_b_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(db_en) && $past(a_in) |-> !out_b);

    assert_zero_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(db_en) && ($past(rise_dly) == '0) |-> out_a == $past(a_in));

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(db_en) |-> !(out_a && out_b));
endmodule

bind deadband_gen dbg_checker #(.W(DLY_W)) u_dbg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .db_en    (db_en),
    .rise_dly (rise_dly),
    .a_in     (a_in),
    .b_in     (b_in),
    .out_a    (out_a),
    .out_b    (out_b)
);

// File: tb/test_deadband_gen.sv
`timescale 1ns/1ps
module test_deadband_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        db_en = 1'b0;
    logic [11:0] rise_dly = '0;
    logic [11:0] fall_dly = '0;
    logic        a_in = 1'b0;
    logic        b_in = 1'b0;
    logic        out_a, out_b;

    int total = 0;
    int bad = 0;
    int m_run = 0;
    bit m_lvl = 1'b0;
    string ovr_a = "";
    string ovr_b = "";

    always #2.5 clk = ~clk;

    deadband_gen i_deadband_gen (
        .clk(clk), .rst_n(rst_n), .db_en(db_en),
        .rise_dly(rise_dly), .fall_dly(fall_dly),
        .a_in(a_in), .b_in(b_in), .out_a(out_a), .out_b(out_b)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive at negedge, model the edge, compare at the following negedge
    task automatic tick(input bit a, input bit b);
        bit ea, eb;
        string ta, tb;
        a_in = a;
        b_in = b;
        @(posedge clk);
        if (a == m_lvl) begin
            if (m_run < 5000) m_run++;
        end else begin
            m_run = 1;
        end
        m_lvl = a;
        if (db_en) begin
            ea = a && (m_run >= int'(rise_dly) + 1);
            eb = !a && (m_run >= int'(fall_dly) + 1);
            ta = a ? ((rise_dly == 0) ? "R9" : "R3") : "R4";
            tb = a ? "R6" : ((fall_dly == 0) ? "R9" : "R5");
        end else begin
            ea = a;
            eb = b;
            ta = "R2";
            tb = "R2";
        end
        if (ovr_a != "") ta = ovr_a;
        if (ovr_b != "") tb = ovr_b;
        @(negedge clk);
        check({ta, " out_a"}, out_a, ea);
        check({tb, " out_b"}, out_b, eb);
        if (db_en) check("R10 overlap", out_a && out_b, 1'b0);
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            a_in = i[0];
            b_in = 1'b1;
            @(negedge clk);
            check("R1 reset out_a", out_a, 1'b0);
            check("R1 reset out_b", out_b, 1'b0);
        end
        a_in = 1'b0;
        rst_n = 1'b1;
        m_lvl = 1'b0;
        m_run = 0;

        // R2: transparent mode, independent channels
        db_en = 1'b0;
        for (int i = 0; i < 64; i++) tick(i[0] ^ i[3], i[1] ^ i[4]);

        // Guard-mode sweep over delays and pulse lengths, b_in toggling (R7)
        db_en = 1'b1;
        for (int rd = 0; rd < 6; rd++) begin
            for (int fd = 0; fd < 6; fd++) begin
                rise_dly = 12'(rd);
                fall_dly = 12'(fd);
                for (int hi = 1; hi < 8; hi++) begin
                    for (int lo = 1; lo < 8; lo++) begin
                        ovr_a = (hi <= rd) ? "R8" : "";
                        for (int k = 0; k < hi; k++) tick(1'b1, k[0]);
                        ovr_a = "";
                        ovr_b = (lo <= fd) ? "R8" : "";
                        for (int k = 0; k < lo; k++) tick(1'b0, ~k[0]);
                        ovr_b = "";
                    end
                end
            end
        end

        // R7: raw b_in ignored while guard mode is on
        rise_dly = 12'd2;
        fall_dly = 12'd2;
        ovr_a = "R7";
        ovr_b = "R7";
        for (int i = 0; i < 12; i++) tick(1'b1, i[0]);
        for (int i = 0; i < 12; i++) tick(1'b0, ~i[1]);
        ovr_a = "";
        ovr_b = "";

        // R11: maximum delays and saturation of long runs
        rise_dly = 12'd4095;
        fall_dly = 12'd4095;
        ovr_a = "R11";
        ovr_b = "R11";
        for (int i = 0; i < 4200; i++) tick(1'b1, 1'b0);
        for (int i = 0; i < 4200; i++) tick(1'b0, 1'b1);
        ovr_a = "";
        ovr_b = "";

        // Back to transparent after guard mode (R2)
        db_en = 1'b0;
        for (int i = 0; i < 16; i++) tick(i[1], i[0]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule